// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter-gather segments into a table of physical region descriptors for a bus-mastering disk controller. Each segment is a 32-bit bus address and a byte length. Each segment is cut into chunks so that no chunk crosses a 64 KB address boundary. For every chunk the block writes a two-word descriptor through a table write port: first the address word, then the count word.

Two mode inputs select how the count word is encoded. In byte mode the count sits in the low half, and 0 stands for 64 KB. In word-granular mode, for controllers that move 32-bit units, the count word holds the number of 4-byte units minus one in bits 31:16. An optional split setting breaks a full 64 KB chunk into two 32 KB descriptors, because some controllers read the 0 count as zero bytes.

The last descriptor carries an end flag in bit 31 of its count word. When the table runs out of room, or when no descriptor was produced at all, the block stops and raises an error strobe. The requester then falls back to programmed I/O. After finishing, the block accepts no segment until `restart` is pulsed. The mode inputs must stay stable during a job.

Top module: `prd_table_gen`

## Requirements
- R1: A chunk's byte count is the smaller of the bytes left in the segment and 0x10000 minus the low 16 bits of the chunk's address. The next chunk starts at the address plus that count. Consecutive segments are processed in arrival order.
- R2: Descriptor k is written as two words. The address word goes to table word index 2k and the count word to 2k+1, with the address word written in the cycle before the count word.
- R3: With `mode_dword` low, the count word holds the byte count in bits 15:0 and zeros in bits 30:16. A 64 KB chunk is encoded as 0x0000.
- R4: With `mode_split64` high and `mode_dword` low, a 64 KB chunk becomes two descriptors of 0x8000 bytes, at the address and at the address plus 0x8000. With `mode_dword` high, `mode_split64` has no effect.
- R5: With `mode_dword` high, bits 31:16 of the count word are (bytes/4)-1 and bits 15:0 are zero.
- R6: Bit 31 of the count word is 1 on the final descriptor of a job and 0 on every other descriptor.
- R7: If a job needs more than MAX_ENTRIES descriptors, the block writes no descriptor beyond MAX_ENTRIES. It pulses `err_overflow` together with `done`, and `entry_count` equals MAX_ENTRIES. A job that needs exactly MAX_ENTRIES descriptors completes without error.
- R8: If a job produces no descriptor, the block pulses `err_empty` together with `done`, and `entry_count` is 0.
- R9: A zero-length segment produces no descriptor. If the zero-length segment is the last one and descriptors exist, the end flag is set on the count word of the previously written descriptor.
- R10: `done` is a one-cycle pulse, and `entry_count` holds the number of descriptors written. After `done`, `seg_ready` stays low until `restart`. `restart` clears the count and raises `seg_ready` again.
- R11: After reset, `seg_ready` is 1, `entry_count` is 0, and `tbl_we`, `done`, `err_overflow` and `err_empty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Clears the table count and starts a new job |
| mode_split64 | input | 1 | Break 64 KB chunks into two 32 KB descriptors |
| mode_dword | input | 1 | Count word in 4-byte units minus one, bits 31:16 |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the job |
| tbl_we | output | 1 | Table word write enable |
| tbl_waddr | output | TBL_AW | Table word index |
| tbl_wdata | output | 32 | Table word data |
| entry_count | output | CNT_W | Descriptors written in this job |
| done | output | 1 | Job finished (one cycle) |
| err_overflow | output | 1 | Table too small, use programmed I/O |
| err_empty | output | 1 | No descriptor produced |

## Verification
Two functions can fall in the same cycle: the end-of-table flag on the final descriptor, and the capacity check. A job that ends exactly in the last free slot must set the flag and raise no error. A job needing one more descriptor, or a split 64 KB chunk arriving with only one slot left, must raise overflow with the count at capacity. The bench provokes both edges with single large aligned segments and with many small segments followed by a full 64 KB chunk in split mode. It judges the table contents, the error strobes and `entry_count` against an independent model of the chunking rules.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;

  typedef enum logic [2:0] {
    ST_IN,
    ST_ADDR,
    ST_CNT,
    ST_MARK,
    ST_END
  } prd_state_e;

  localparam logic [31:0] PRD_END_FLAG = 32'h8000_0000;
  localparam logic [16:0] PRD_SPAN     = 17'h1_0000;
  localparam logic [16:0] PRD_HALF     = 17'h0_8000;

endpackage

// File: rtl/prd_chunk_calc.sv
`timescale 1ns/1ps
module prd_chunk_calc #(
  parameter int LEN_W = 24
) (
  input  logic [15:0]      addr_lo,
  input  logic [LEN_W-1:0] rem,
  input  logic             split_en,
  output logic [16:0]      chunk
);
  import prd_pkg::*;

  logic [16:0]      room;
  logic [LEN_W-1:0] room_w;

  always_comb begin
    room   = PRD_SPAN - {1'b0, addr_lo};
    room_w = LEN_W'(room);
    if (rem < room_w) chunk = rem[16:0];
    else              chunk = room;
    if (split_en && (chunk == PRD_SPAN)) chunk = PRD_HALF;
  end

endmodule

// File: rtl/prd_count_enc.sv
`timescale 1ns/1ps
module prd_count_enc (
  input  logic [16:0] chunk,
  input  logic        dword,
  input  logic        final_ent,
  output logic [31:0] word
);
  import prd_pkg::*;

  logic [16:0] units_m1;

  always_comb begin
    units_m1 = (chunk >> 2) - 17'd1;
    if (dword) word = {units_m1[15:0], 16'h0000};
    else       word = {16'h0000, chunk[15:0]};
    if (final_ent) word = word | PRD_END_FLAG;
  end

endmodule

// File: rtl/prd_ctrl.sv
`timescale 1ns/1ps
module prd_ctrl #(
  parameter int LEN_W       = 24,
  parameter int MAX_ENTRIES = 16,
  parameter int IDX_W       = 4,
  parameter int CNT_W       = 5,
  parameter int TBL_AW      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic [31:0]       cur_addr,
  output logic [LEN_W-1:0]  cur_rem,
  output logic              final_ent,
  input  logic [16:0]       chunk,
  input  logic [31:0]       cnt_word,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_waddr,
  output logic [31:0]       tbl_wdata,
  output logic [CNT_W-1:0]  entry_count,
  output logic              done,
  output logic              err_overflow,
  output logic              err_empty
);
  import prd_pkg::*;

  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ENTRIES);

  prd_state_e       state;
  logic             last_q;
  logic [16:0]      chunk_q;
  logic [31:0]      word_q;
  logic [31:0]      prev_word;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] count_m1;
  logic             full;

  assign seg_ready   = (state == ST_IN);
  assign entry_count = count;
  assign full        = (count == CAP);
  assign count_m1    = count - CNT_W'(1);
  assign final_ent   = last_q && (cur_rem == LEN_W'(chunk));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IN;
      last_q       <= 1'b0;
      chunk_q      <= '0;
      word_q       <= '0;
      prev_word    <= '0;
      count        <= '0;
      cur_addr     <= '0;
      cur_rem      <= '0;
      tbl_we       <= 1'b0;
      tbl_waddr    <= '0;
      tbl_wdata    <= '0;
      done         <= 1'b0;
      err_overflow <= 1'b0;
      err_empty    <= 1'b0;
    end else begin
      tbl_we       <= 1'b0;
      done         <= 1'b0;
      err_overflow <= 1'b0;
      err_empty    <= 1'b0;
      if (restart) begin
        state <= ST_IN;
        count <= '0;
      end else begin
        case (state)
          ST_IN: begin
            if (seg_valid) begin
              cur_addr <= seg_addr;
              cur_rem  <= seg_len;
              last_q   <= seg_last;
              if (seg_len == '0) begin
                if (seg_last) begin
                  if (count == '0) begin
                    err_empty <= 1'b1;
                    done      <= 1'b1;
                    state     <= ST_END;
                  end else begin
                    state <= ST_MARK;
                  end
                end
              end else begin
                state <= ST_ADDR;
              end
            end
          end
          ST_ADDR: begin
            if (full) begin
              err_overflow <= 1'b1;
              done         <= 1'b1;
              state        <= ST_END;
            end else begin
              tbl_we    <= 1'b1;
              tbl_waddr <= {count[IDX_W-1:0], 1'b0};
              tbl_wdata <= cur_addr;
              word_q    <= cnt_word;
              chunk_q   <= chunk;
              state     <= ST_CNT;
            end
          end
          ST_CNT: begin
            tbl_we    <= 1'b1;
            tbl_waddr <= {count[IDX_W-1:0], 1'b1};
            tbl_wdata <= word_q;
            prev_word <= word_q;
            count     <= count + CNT_W'(1);
            cur_addr  <= cur_addr + 32'(chunk_q);
            cur_rem   <= cur_rem - LEN_W'(chunk_q);
            if (cur_rem == LEN_W'(chunk_q)) begin
              if (last_q) begin
                done  <= 1'b1;
                state <= ST_END;
              end else begin
                state <= ST_IN;
              end
            end else begin
              state <= ST_ADDR;
            end
          end
          ST_MARK: begin
            tbl_we    <= 1'b1;
            tbl_waddr <= {count_m1[IDX_W-1:0], 1'b1};
            tbl_wdata <= prev_word | PRD_END_FLAG;
            done      <= 1'b1;
            state     <= ST_END;
          end
          default: begin
          end
        endcase
      end
    end
  end

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |-> (({2'b00, cur_addr[15:0]} + {1'b0, chunk}) <= 18'h1_0000)); // R1

  AST_WORD_PAIR: assert property (@(posedge clk) disable iff (rst || restart)
    (tbl_we && !tbl_waddr[0]) |=> (tbl_we && tbl_waddr[0])); // R2

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst)
    (err_overflow || err_empty) |-> done); // R7

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    entry_count <= CAP); // R7

  AST_EMPTY_CNT: assert property (@(posedge clk) disable iff (rst)
    err_empty |-> (entry_count == '0)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_HALT_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> !seg_ready); // R10

endmodule

// File: rtl/prd_table_gen.sv
`timescale 1ns/1ps
module prd_table_gen #(
  parameter int LEN_W       = 24,
  parameter int MAX_ENTRIES = 16,
  parameter int IDX_W       = $clog2(MAX_ENTRIES),
  parameter int CNT_W       = $clog2(MAX_ENTRIES + 1),
  parameter int TBL_AW      = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              mode_split64,
  input  logic              mode_dword,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_waddr,
  output logic [31:0]       tbl_wdata,
  output logic [CNT_W-1:0]  entry_count,
  output logic              done,
  output logic              err_overflow,
  output logic              err_empty
);

  logic [31:0]      cur_addr;
  logic [LEN_W-1:0] cur_rem;
  logic [16:0]      chunk;
  logic [31:0]      cnt_word;
  logic             final_ent;
  logic             split_en;

  assign split_en = mode_split64 && !mode_dword;

  prd_chunk_calc #(.LEN_W(LEN_W)) u_calc (
    .addr_lo  (cur_addr[15:0]),
    .rem      (cur_rem),
    .split_en (split_en),
    .chunk    (chunk)
  );

  prd_count_enc u_enc (
    .chunk     (chunk),
    .dword     (mode_dword),
    .final_ent (final_ent),
    .word      (cnt_word)
  );

  prd_ctrl #(
    .LEN_W       (LEN_W),
    .MAX_ENTRIES (MAX_ENTRIES),
    .IDX_W       (IDX_W),
    .CNT_W       (CNT_W),
    .TBL_AW      (TBL_AW)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .restart      (restart),
    .seg_valid    (seg_valid),
    .seg_ready    (seg_ready),
    .seg_addr     (seg_addr),
    .seg_len      (seg_len),
    .seg_last     (seg_last),
    .cur_addr     (cur_addr),
    .cur_rem      (cur_rem),
    .final_ent    (final_ent),
    .chunk        (chunk),
    .cnt_word     (cnt_word),
    .tbl_we       (tbl_we),
    .tbl_waddr    (tbl_waddr),
    .tbl_wdata    (tbl_wdata),
    .entry_count  (entry_count),
    .done         (done),
    .err_overflow (err_overflow),
    .err_empty    (err_empty)
  );

endmodule

// File: tb/sim_prd_table_gen.sv
`timescale 1ns/1ps
module sim_prd_table_gen;

  localparam int MAXE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        restart = 1'b0;
  logic        mode_split64 = 1'b0;
  logic        mode_dword = 1'b0;
  logic        seg_valid = 1'b0;
  logic        seg_ready;
  logic [31:0] seg_addr = '0;
  logic [23:0] seg_len = '0;
  logic        seg_last = 1'b0;
  logic        tbl_we;
  logic [4:0]  tbl_waddr;
  logic [31:0] tbl_wdata;
  logic [4:0]  entry_count;
  logic        done;
  logic        err_overflow;
  logic        err_empty;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  prd_table_gen u0 (
    .clk(clk), .rst(rst), .restart(restart),
    .mode_split64(mode_split64), .mode_dword(mode_dword),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .entry_count(entry_count), .done(done),
    .err_overflow(err_overflow), .err_empty(err_empty)
  );

  // segment list and expected table
  logic [31:0] sa [0:31];
  logic [23:0] sl [0:31];
  int          ns;
  logic [31:0] ea [0:31];
  logic [31:0] ec [0:31];
  int          en;
  bit          eovf, eemp;

  // observed
  logic [31:0] cap [0:31];
  bit          got_done, got_ovf, got_emp;
  int          done_cnt;
  logic [4:0]  cnt_at_done;

  always @(negedge clk) begin
    if (tbl_we) cap[tbl_waddr] = tbl_wdata;
    if (done) begin
      got_done    = 1'b1;
      done_cnt    = done_cnt + 1;
      cnt_at_done = entry_count;
      got_ovf     = err_overflow;
      got_emp     = err_empty;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic model(input bit sp, input bit dw);
    en = 0; eovf = 1'b0; eemp = 1'b0;
    for (int i = 0; i < ns && !eovf; i++) begin
      longint a = sa[i];
      longint r = sl[i];
      while (r > 0 && !eovf) begin
        longint room = 65536 - (a & 16'hFFFF);
        longint c = (r < room) ? r : room;
        if (sp && !dw && c == 65536) c = 32768;
        if (en == MAXE) begin
          eovf = 1'b1;
        end else begin
          ea[en] = a[31:0];
          if (dw) ec[en] = {16'(((c >> 2) - 1) & 16'hFFFF), 16'h0000};
          else    ec[en] = {16'h0000, 16'(c & 16'hFFFF)};
          en++;
          a = a + c;
          r = r - c;
        end
      end
    end
    if (en == 0) eemp = 1'b1;
    else if (!eovf) ec[en-1] = ec[en-1] | 32'h8000_0000;
  endtask

  task automatic run_job(input bit sp, input bit dw, input string rq);
    mode_split64 = sp;
    mode_dword   = dw;
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    for (int k = 0; k < 32; k++) cap[k] = 32'hDEAD_BEEF;
    got_done = 1'b0; got_ovf = 1'b0; got_emp = 1'b0; done_cnt = 0;
    for (int i = 0; i < ns; i++) begin
      seg_valid = 1'b1;
      seg_addr  = sa[i];
      seg_len   = sl[i];
      seg_last  = (i == ns - 1);
      while (!seg_ready && !got_done) @(negedge clk);
      if (got_done) break;
      @(negedge clk);
    end
    seg_valid = 1'b0;
    seg_last  = 1'b0;
    for (int w = 0; w < 5000 && !got_done; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    model(sp, dw);
    check(got_done, rq, "done seen", 32'(got_done), 32'd1);
    check(done_cnt == 1, "R10", "done pulse count", 32'(done_cnt), 32'd1);
    check(seg_ready == 1'b0, "R10", "ready low after done", 32'(seg_ready), 32'd0);
    check(got_ovf == eovf, "R7", "overflow flag", 32'(got_ovf), 32'(eovf));
    check(got_emp == eemp, "R8", "empty flag", 32'(got_emp), 32'(eemp));
    check(32'(cnt_at_done) == 32'(en), rq, "entry count", 32'(cnt_at_done), 32'(en));
    for (int k = 0; k < en; k++) begin
      check(cap[2*k] == ea[k], rq, $sformatf("addr word %0d", k), cap[2*k], ea[k]);
      check(cap[2*k+1] == ec[k], rq, $sformatf("count word %0d", k), cap[2*k+1], ec[k]);
    end
    if (en < MAXE)
      check(cap[2*en] == 32'hDEAD_BEEF, "R7", "no write past end",
            cap[2*en], 32'hDEAD_BEEF);
  endtask

  task automatic t_reset;
    check(seg_ready == 1'b1, "R11", "ready after reset", 32'(seg_ready), 32'd1);
    check(entry_count == '0, "R11", "count after reset", 32'(entry_count), 32'd0);
    check(!tbl_we && !done && !err_overflow && !err_empty, "R11", "strobes after reset",
          {28'd0, tbl_we, done, err_overflow, err_empty}, 32'd0);
  endtask

  task automatic t_single;   // R2 R3 R6
    ns = 1; sa[0] = 32'h0000_1000; sl[0] = 24'h200;
    run_job(1'b0, 1'b0, "R2");
    check(cap[1] == 32'h8000_0200, "R6", "single entry end flag", cap[1], 32'h8000_0200);
  endtask

  task automatic t_cross;    // R1
    ns = 1; sa[0] = 32'h0001_F000; sl[0] = 24'h3000;
    run_job(1'b0, 1'b0, "R1");
    check(cap[2] == 32'h0002_0000, "R1", "second chunk address", cap[2], 32'h0002_0000);
  endtask

  task automatic t_full64;   // R3
    ns = 1; sa[0] = 32'h0003_0000; sl[0] = 24'h1_0000;
    run_job(1'b0, 1'b0, "R3");
    check(cap[1] == 32'h8000_0000, "R3", "64KB encodes as zero", cap[1], 32'h8000_0000);
  endtask

  task automatic t_split;    // R4
    ns = 1; sa[0] = 32'h0003_0000; sl[0] = 24'h1_0000;
    run_job(1'b1, 1'b0, "R4");
    check(cap[3] == 32'h8000_8000 && cap[2] == 32'h0003_8000, "R4", "split second half",
          cap[3], 32'h8000_8000);
  endtask

  task automatic t_dword;    // R5, split ignored in this mode (R4)
    ns = 2; sa[0] = 32'h0000_0100; sl[0] = 24'h400;
    sa[1] = 32'h0005_0000; sl[1] = 24'h1_0000;
    run_job(1'b1, 1'b1, "R5");
    check(cap[1] == 32'h00FF_0000, "R5", "dword count", cap[1], 32'h00FF_0000);
    check(cap[3] == 32'hBFFF_0000, "R4", "no split in dword mode", cap[3], 32'hBFFF_0000);
  endtask

  task automatic t_multi;    // R1 R2 R6
    ns = 3;
    sa[0] = 32'h1000_FF00; sl[0] = 24'h300;
    sa[1] = 32'h2000_0000; sl[1] = 24'h2_0010;
    sa[2] = 32'h3000_0040; sl[2] = 24'h80;
    run_job(1'b0, 1'b0, "R6");
  endtask

  task automatic t_exact;    // R7 edge: fills table exactly
    ns = 1; sa[0] = 32'h0; sl[0] = 24'h10_0000;
    run_job(1'b0, 1'b0, "R7");
  endtask

  task automatic t_ovf;      // R7
    ns = 1; sa[0] = 32'h0; sl[0] = 24'h11_0000;
    run_job(1'b0, 1'b0, "R7");
  endtask

  task automatic t_split_ovf; // R4 with R7: split needs two slots, one left
    ns = 16;
    for (int i = 0; i < 15; i++) begin sa[i] = 32'h100 * i; sl[i] = 24'h10; end
    sa[15] = 32'h0009_0000; sl[15] = 24'h1_0000;
    run_job(1'b1, 1'b0, "R7");
  endtask

  task automatic t_empty;    // R8
    ns = 2; sa[0] = 32'h1234; sl[0] = 24'h0; sa[1] = 32'h5678; sl[1] = 24'h0;
    run_job(1'b0, 1'b0, "R8");
  endtask

  task automatic t_zero;     // R9
    ns = 3;
    sa[0] = 32'h0000_4000; sl[0] = 24'h100;
    sa[1] = 32'h0000_8000; sl[1] = 24'h0;
    sa[2] = 32'h0000_C000; sl[2] = 24'h0;
    run_job(1'b0, 1'b0, "R9");
    check(cap[1] == 32'h8000_0100, "R9", "flag moved to previous", cap[1], 32'h8000_0100);
  endtask

  task automatic t_halt;     // R10
    repeat (4) @(negedge clk);
    check(seg_ready == 1'b0, "R10", "ready held low", 32'(seg_ready), 32'd0);
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    check(seg_ready == 1'b1, "R10", "ready after restart", 32'(seg_ready), 32'd1);
    check(entry_count == '0, "R10", "count after restart", 32'(entry_count), 32'd0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_cross();
    t_full64();
    t_split();
    t_dword();
    t_multi();
    t_exact();
    t_ovf();
    t_split_ovf();
    t_empty();
    t_zero();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule